// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control sequencer of a 32-bit multicycle load/store processor in which a single ALU and a single memory port are shared over successive steps of an instruction. A Moore state machine walks each instruction through only the steps it needs. Every instruction starts with a fetch step and a decode step. After that, the sequencer follows one of several paths: register ALU operation, load, store, conditional branch, or a load whose address is the sum of two registers. The sequencer drives the datapath enables and multiplexer selects straight from its current state.

The opcode and function fields of the latched instruction are inputs. The sequencer reads them only on the clock edge that leaves decode. After that edge the path is fixed, and later changes on those inputs have no effect until the next fetch. The datapath, memory and register file are outside this block.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: While `rst_ni` is low, the outputs show the fetch pattern. Reset is asynchronous. After release, the first cycle is a fetch.
- R2: The fetch step asserts `mem_rd_o`, `ir_we_o` and `pc_we_o`, with `addr_sel_o`=0, `alu_a_sel_o`=0, `alu_b_sel_o`=01 (constant 4), `alu_op_o`=00 and `pc_src_o`=00. All other strobes are 0.
- R3: Each fetch is followed by one decode step: `alu_a_sel_o`=0, `alu_b_sel_o`=11 (shifted offset), `alu_op_o`=00 (add), and no strobes.
- R4: Opcode 000000 with any function code other than the reserved one takes 4 cycles. Step 3 is `alu_a_sel_o`=1, `alu_b_sel_o`=00, `alu_op_o`=10. Step 4 is `rf_we_o`=1 and `dst_sel_o`=1, with `wb_sel_o`=0.
- R5: Opcode 100011 (load) takes 5 cycles. Step 3 forms the address (`alu_a_sel_o`=1, `alu_b_sel_o`=10, `alu_op_o`=00). Step 4 reads memory (`mem_rd_o`=1, `addr_sel_o`=1). Step 5 writes back (`rf_we_o`=1, `wb_sel_o`=1, `dst_sel_o`=0).
- R6: Opcode 101011 (store) takes 4 cycles. Step 3 is the same address step as for a load. Step 4 writes memory (`mem_wr_o`=1, `addr_sel_o`=1).
- R7: Opcode 000100 (branch) takes 3 cycles. Step 3 compares the registers: `alu_a_sel_o`=1, `alu_b_sel_o`=00, `alu_op_o`=01, `pc_we_cond_o`=1, `pc_src_o`=01.
- R8: Opcode 000000 with function code `LDRR_FN` (default 111111) takes 5 cycles through three dedicated steps. The first adds two registers (`alu_a_sel_o`=1, `alu_b_sel_o`=00, `alu_op_o`=00). The second reads memory (`mem_rd_o`=1, `addr_sel_o`=1). The third writes to the rd register (`rf_we_o`, `dst_sel_o` and `wb_sel_o` all 1).
- R9: Any other opcode returns to fetch right after decode. No register, memory or PC write is asserted in between.
- R10: Changes on `opcode_i`/`funct_i` after the decode step has been left do not alter the remaining steps of the current instruction.
- R11: `mem_rd_o` and `mem_wr_o` are never both 1. At most one of `rf_we_o`, `mem_wr_o`, `pc_we_o` and `pc_we_cond_o` is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| opcode_i | input | 6 | Opcode field of the latched instruction |
| funct_i | input | 6 | Function field of the latched instruction |
| pc_we_o | output | 1 | Unconditional PC write |
| pc_we_cond_o | output | 1 | PC write if the branch compare is equal |
| addr_sel_o | output | 1 | Memory address: 0 = PC, 1 = ALU result register |
| mem_rd_o | output | 1 | Memory read |
| mem_wr_o | output | 1 | Memory write |
| ir_we_o | output | 1 | Instruction register load |
| wb_sel_o | output | 1 | Write-back data: 0 = ALU result, 1 = memory data register |
| dst_sel_o | output | 1 | Destination register: 0 = rt field, 1 = rd field |
| rf_we_o | output | 1 | Register file write |
| alu_a_sel_o | output | 1 | ALU A: 0 = PC, 1 = register A |
| alu_b_sel_o | output | 2 | ALU B: 00 reg B, 01 constant 4, 10 immediate, 11 shifted immediate |
| alu_op_o | output | 2 | 00 add, 01 subtract, 10 function-field operation |
| pc_src_o | output | 2 | PC source: 00 ALU, 01 ALU result register |

## Verification
The embedded assertions check on every cycle that the write strobes are mutually exclusive. They also check the fixed successors: decode after fetch, fetch after the last step of each path, and the order of the three steps of the register-plus-register load. Only the bench scenarios can show the following: the full per-cycle strobe sequence and the cycle count of each instruction class, which path the decode of each opcode/function pair selects, the return of an unknown opcode, that inputs changed mid-instruction are ignored, and the asynchronous reset taking effect in the middle of an instruction.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;

  localparam int unsigned OP_W = 6;
  localparam int unsigned FN_W = 6;

  localparam logic [OP_W-1:0] OPC_RTYPE  = 6'b000000;
  localparam logic [OP_W-1:0] OPC_LOAD   = 6'b100011;
  localparam logic [OP_W-1:0] OPC_STORE  = 6'b101011;
  localparam logic [OP_W-1:0] OPC_BRANCH = 6'b000100;

  typedef enum logic [3:0] {
    ST_FETCH  = 4'd0,
    ST_DECODE = 4'd1,
    ST_ADR_LD = 4'd2,
    ST_ADR_ST = 4'd3,
    ST_MEM_RD = 4'd4,
    ST_MEM_WB = 4'd5,
    ST_MEM_WR = 4'd6,
    ST_EXEC   = 4'd7,
    ST_ALU_WB = 4'd8,
    ST_BRANCH = 4'd9,
    ST_RR_ADD = 4'd10,
    ST_RR_RD  = 4'd11,
    ST_RR_WB  = 4'd12
  } state_e;

  typedef enum logic [2:0] {
    CLS_NONE,
    CLS_ALU,
    CLS_RRLD,
    CLS_LOAD,
    CLS_STORE,
    CLS_BRANCH
  } iclass_e;

  typedef struct packed {
    logic       pc_we;
    logic       pc_we_cond;
    logic       addr_sel;
    logic       mem_rd;
    logic       mem_wr;
    logic       ir_we;
    logic       wb_sel;
    logic       dst_sel;
    logic       rf_we;
    logic       alu_a_sel;
    logic [1:0] alu_b_sel;
    logic [1:0] alu_op;
    logic [1:0] pc_src;
  } ctrl_t;

endpackage

// File: rtl/mc_op_decode.sv
module mc_op_decode
  import mc_ctrl_pkg::*;
#(
  parameter logic [FN_W-1:0] LDRR_FN = 6'b111111
) (
  input  logic [OP_W-1:0] opcode_i,
  input  logic [FN_W-1:0] funct_i,
  output iclass_e         cls_o
);

  always_comb begin
    unique case (opcode_i)
      OPC_RTYPE:  cls_o = (funct_i == LDRR_FN) ? CLS_RRLD : CLS_ALU;
      OPC_LOAD:   cls_o = CLS_LOAD;
      OPC_STORE:  cls_o = CLS_STORE;
      OPC_BRANCH: cls_o = CLS_BRANCH;
      default:    cls_o = CLS_NONE;
    endcase
  end

endmodule

// File: rtl/mc_next_state.sv
module mc_next_state
  import mc_ctrl_pkg::*;
(
  input  state_e  state_i,
  input  iclass_e cls_i,
  output state_e  state_o
);

  always_comb begin
    state_o = ST_FETCH;
    unique case (state_i)
      ST_FETCH:  state_o = ST_DECODE;
      ST_DECODE: begin
        unique case (cls_i)
          CLS_ALU:    state_o = ST_EXEC;
          CLS_RRLD:   state_o = ST_RR_ADD;
          CLS_LOAD:   state_o = ST_ADR_LD;
          CLS_STORE:  state_o = ST_ADR_ST;
          CLS_BRANCH: state_o = ST_BRANCH;
          default:    state_o = ST_FETCH;
        endcase
      end
      // load/store split into distinct address states so opcode is not re-read
      ST_ADR_LD: state_o = ST_MEM_RD;
      ST_ADR_ST: state_o = ST_MEM_WR;
      ST_MEM_RD: state_o = ST_MEM_WB;
      ST_EXEC:   state_o = ST_ALU_WB;
      ST_RR_ADD: state_o = ST_RR_RD;
      ST_RR_RD:  state_o = ST_RR_WB;
      default:   state_o = ST_FETCH;
    endcase
  end

endmodule

// File: rtl/mc_ctrl_out.sv
module mc_ctrl_out
  import mc_ctrl_pkg::*;
(
  input  state_e state_i,
  output ctrl_t  ctrl_o
);

  always_comb begin
    ctrl_o = '0;
    unique case (state_i)
      ST_FETCH: begin
        ctrl_o.mem_rd    = 1'b1;
        ctrl_o.ir_we     = 1'b1;
        ctrl_o.pc_we     = 1'b1;
        ctrl_o.alu_b_sel = 2'b01;
      end
      ST_DECODE: ctrl_o.alu_b_sel = 2'b11;
      ST_ADR_LD, ST_ADR_ST: begin
        ctrl_o.alu_a_sel = 1'b1;
        ctrl_o.alu_b_sel = 2'b10;
      end
      ST_MEM_RD, ST_RR_RD: begin
        ctrl_o.mem_rd   = 1'b1;
        ctrl_o.addr_sel = 1'b1;
      end
      ST_MEM_WB: begin
        ctrl_o.rf_we  = 1'b1;
        ctrl_o.wb_sel = 1'b1;
      end
      ST_MEM_WR: begin
        ctrl_o.mem_wr   = 1'b1;
        ctrl_o.addr_sel = 1'b1;
      end
      ST_EXEC: begin
        ctrl_o.alu_a_sel = 1'b1;
        ctrl_o.alu_op    = 2'b10;
      end
      ST_ALU_WB: begin
        ctrl_o.rf_we   = 1'b1;
        ctrl_o.dst_sel = 1'b1;
      end
      ST_BRANCH: begin
        ctrl_o.alu_a_sel  = 1'b1;
        ctrl_o.alu_op     = 2'b01;
        ctrl_o.pc_we_cond = 1'b1;
        ctrl_o.pc_src     = 2'b01;
      end
      ST_RR_ADD: ctrl_o.alu_a_sel = 1'b1;
      ST_RR_WB: begin
        ctrl_o.rf_we   = 1'b1;
        ctrl_o.dst_sel = 1'b1;
        ctrl_o.wb_sel  = 1'b1;
      end
      default: ctrl_o = '0;
    endcase
  end

endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
  import mc_ctrl_pkg::*;
#(
  parameter logic [FN_W-1:0] LDRR_FN = 6'b111111
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [OP_W-1:0] opcode_i,
  input  logic [FN_W-1:0] funct_i,
  output logic            pc_we_o,
  output logic            pc_we_cond_o,
  output logic            addr_sel_o,
  output logic            mem_rd_o,
  output logic            mem_wr_o,
  output logic            ir_we_o,
  output logic            wb_sel_o,
  output logic            dst_sel_o,
  output logic            rf_we_o,
  output logic            alu_a_sel_o,
  output logic [1:0]      alu_b_sel_o,
  output logic [1:0]      alu_op_o,
  output logic [1:0]      pc_src_o
);

  state_e  state_q, state_d;
  iclass_e cls;
  ctrl_t   ctrl;

  mc_op_decode #(.LDRR_FN(LDRR_FN)) u_dec (
    .opcode_i(opcode_i),
    .funct_i (funct_i),
    .cls_o   (cls)
  );

  mc_next_state u_nxt (
    .state_i(state_q),
    .cls_i  (cls),
    .state_o(state_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_FETCH;
    else         state_q <= state_d;
  end

  mc_ctrl_out u_out (
    .state_i(state_q),
    .ctrl_o (ctrl)
  );

  assign pc_we_o      = ctrl.pc_we;
  assign pc_we_cond_o = ctrl.pc_we_cond;
  assign addr_sel_o   = ctrl.addr_sel;
  assign mem_rd_o     = ctrl.mem_rd;
  assign mem_wr_o     = ctrl.mem_wr;
  assign ir_we_o      = ctrl.ir_we;
  assign wb_sel_o     = ctrl.wb_sel;
  assign dst_sel_o    = ctrl.dst_sel;
  assign rf_we_o      = ctrl.rf_we;
  assign alu_a_sel_o  = ctrl.alu_a_sel;
  assign alu_b_sel_o  = ctrl.alu_b_sel;
  assign alu_op_o     = ctrl.alu_op;
  assign pc_src_o     = ctrl.pc_src;

  AST_MEM_RD_WR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o)); // R11
  AST_WRITE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rf_we_o, mem_wr_o, pc_we_o, pc_we_cond_o})); // R11
  AST_FETCH_TO_DECODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ir_we_o |=> (alu_b_sel_o == 2'b11 && !mem_rd_o)); // R3
  AST_BRANCH_RETURN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_we_cond_o |=> (ir_we_o && pc_we_o)); // R7
  AST_RR_ADD_TO_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RR_ADD) |=> (state_q == ST_RR_RD)); // R8
  AST_RR_RD_TO_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RR_RD) |=> (rf_we_o && dst_sel_o && wb_sel_o)); // R8
  AST_WB_RETURN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |=> ir_we_o); // R4
  AST_STORE_RETURN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |=> ir_we_o); // R6

endmodule

// File: tb/mc_ctrl_fsm_bench.sv
module mc_ctrl_fsm_bench;

  // expected vector order: pc_we pc_we_cond addr_sel mem_rd mem_wr ir_we
  // wb_sel dst_sel rf_we alu_a_sel alu_b_sel[1:0] alu_op[1:0] pc_src[1:0]
  localparam logic [15:0] V_FETCH  = 16'b1001_0100_0001_0000;
  localparam logic [15:0] V_DECODE = 16'b0000_0000_0011_0000;
  localparam logic [15:0] V_ADR    = 16'b0000_0000_0110_0000;
  localparam logic [15:0] V_MRD    = 16'b0011_0000_0000_0000;
  localparam logic [15:0] V_MWB    = 16'b0000_0010_1000_0000;
  localparam logic [15:0] V_MWR    = 16'b0010_1000_0000_0000;
  localparam logic [15:0] V_EXEC   = 16'b0000_0000_0100_1000;
  localparam logic [15:0] V_RWB    = 16'b0000_0001_1000_0000;
  localparam logic [15:0] V_BR     = 16'b0100_0000_0100_0101;
  localparam logic [15:0] V_RRADD  = 16'b0000_0000_0100_0000;
  localparam logic [15:0] V_RRWB   = 16'b0000_0011_1000_0000;

  typedef struct {
    logic [15:0] v;
    string       tag;
  } item_t;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [5:0] opcode_i = 6'd0;
  logic [5:0] funct_i = 6'd0;
  logic pc_we_o, pc_we_cond_o, addr_sel_o, mem_rd_o, mem_wr_o, ir_we_o;
  logic wb_sel_o, dst_sel_o, rf_we_o, alu_a_sel_o;
  logic [1:0] alu_b_sel_o, alu_op_o, pc_src_o;

  int n_chk = 0;
  int n_bad = 0;
  item_t sb_q[$];

  always #5 clk_i = ~clk_i;

  mc_ctrl_fsm u_mc_ctrl_fsm (
    .clk_i, .rst_ni, .opcode_i, .funct_i,
    .pc_we_o, .pc_we_cond_o, .addr_sel_o, .mem_rd_o, .mem_wr_o, .ir_we_o,
    .wb_sel_o, .dst_sel_o, .rf_we_o, .alu_a_sel_o, .alu_b_sel_o,
    .alu_op_o, .pc_src_o
  );

  wire [15:0] obs = {pc_we_o, pc_we_cond_o, addr_sel_o, mem_rd_o, mem_wr_o,
                     ir_we_o, wb_sel_o, dst_sel_o, rf_we_o, alu_a_sel_o,
                     alu_b_sel_o, alu_op_o, pc_src_o};

  task automatic check(input logic [15:0] exp, input string tag);
    n_chk++;
    if (obs !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, obs, exp);
    end
  endtask

  // monitor: compare one expected item per cycle
  always @(negedge clk_i) begin
    if (rst_ni && sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      check(it.v, it.tag);
    end
  end

  task automatic push(input logic [15:0] v, input string tag);
    item_t it;
    it.v = v;
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  // driver: called just after a posedge that enters fetch
  task automatic run_instr(input logic [5:0] op, input logic [5:0] fn,
                           input logic [15:0] tail[$], input string tag,
                           input bit scramble);
    opcode_i = op;
    funct_i  = fn;
    push(V_FETCH, {tag, " fetch R2"});
    push(V_DECODE, {tag, " decode R3"});
    foreach (tail[i]) push(tail[i], tag);
    repeat (2) @(posedge clk_i);
    #1;
    if (scramble) begin
      opcode_i = ~op;
      funct_i  = ~fn;
    end
    repeat (tail.size()) @(posedge clk_i);
    #1;
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    check(V_FETCH, "R1 reset state");
    @(posedge clk_i);
    #1 rst_ni = 1'b1;

    run_instr(6'b000000, 6'b100000, '{V_EXEC, V_RWB}, "R4 alu", 1'b0);
    run_instr(6'b100011, 6'b000000, '{V_ADR, V_MRD, V_MWB}, "R5 load", 1'b0);
    run_instr(6'b101011, 6'b010101, '{V_ADR, V_MWR}, "R6 store", 1'b0);
    run_instr(6'b000100, 6'b000000, '{V_BR}, "R7 branch", 1'b0);
    run_instr(6'b000000, 6'b111111, '{V_RRADD, V_MRD, V_RRWB}, "R8 rrload", 1'b0);
    run_instr(6'b111110, 6'b111111, '{}, "R9 unknown", 1'b0);
    run_instr(6'b000010, 6'b000000, '{}, "R9 unknown2", 1'b0);
    run_instr(6'b000000, 6'b111110, '{V_EXEC, V_RWB}, "R4 near-reserved fn", 1'b0);
    run_instr(6'b100011, 6'b000000, '{V_ADR, V_MRD, V_MWB}, "R10 load scrambled", 1'b1);
    run_instr(6'b101011, 6'b000000, '{V_ADR, V_MWR}, "R10 store scrambled", 1'b1);
    run_instr(6'b000000, 6'b111111, '{V_RRADD, V_MRD, V_RRWB}, "R10 rrload scrambled", 1'b1);
    run_instr(6'b000100, 6'b000000, '{V_BR}, "R10 branch scrambled", 1'b1);
    run_instr(6'b000000, 6'b000001, '{V_EXEC, V_RWB}, "R10 alu scrambled", 1'b1);

    // R1: asynchronous reset in the middle of a load
    opcode_i = 6'b100011;
    repeat (3) @(posedge clk_i);
    #2 rst_ni = 1'b0;
    #1 check(V_FETCH, "R1 async reset mid-instruction");
    @(posedge clk_i);
    #1 rst_ni = 1'b1;
    run_instr(6'b000100, 6'b000000, '{V_BR}, "R1 after reset", 1'b0);

    @(negedge clk_i);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule